// File: doc/BRIEF.md
# Shadow Return-Address Stack Checker

This block keeps a private copy of return addresses in a stack that grows downward and that only call flows may fill. When a call goes out, its return address is pushed here while the normal data stack receives its own copy. When a return arrives, the block pops its own copy and compares it with the address the data stack gave back. If they differ, it raises a control-protection fault. Every push and pop also carries a page-attribute flag, and an access whose target page lacks the shadow marking faults instead of completing. Running past either end of the 16-entry storage faults in the same way as touching a guard page.

Checking can be switched on separately for user mode and for supervisor mode. When the current mode has checking switched off, calls and returns pass through with no effect. A generic store port lets ordinary stores try to write the shadow region. The block turns every such attempt away and reports the refusal.

The call, return and store channels carry a valid strobe with no ready. The block takes one event of each kind in every cycle and never applies back-pressure, so a source may present a new event on every clock. The fault, cause, reject and pointer outputs are plain status pins.

Top module: `ssk_shadow_stack`

## Requirements
- R1: After reset the pointer equals DEPTH (16, empty), and fault and st_reject are low.
- R2: The enable in force is en_sup when mode_sup is 1 and en_user otherwise. When that enable is 0, calls and returns cause no fault and leave the pointer and contents unchanged.
- R3: An enabled call with no fault decrements the pointer by one and writes call_addr into the entry the new pointer selects.
- R4: An enabled return whose address equals the entry at the pointer, with no fault, increments the pointer by one.
- R5: An enabled return whose address differs from the stored top entry raises fault with fault_cause 2'b01.
- R6: An enabled push or pop whose page flag is 0 raises fault with fault_cause 2'b10. For a pop this takes precedence over a mismatch.
- R7: A push at pointer 0 or a pop at pointer DEPTH raises fault with fault_cause 2'b11. This takes precedence over the page check.
- R8: A fault is a one-cycle pulse in the cycle after the event. In a cycle that faults, the pointer and contents stay unchanged, even if another event in that cycle was legal.
- R9: A store with st_shadow = 1 is refused. st_reject pulses one cycle later and the shadow contents do not change.
- R10: When a call and a return come in the same cycle, the return is checked and popped first and the call is then pushed. If the return faults, the call is dropped.
- R11: Entries come back in last-in, first-out order through the full depth of 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sup | input | 1 | Current privilege: 1 supervisor, 0 user |
| en_user | input | 1 | Checking enable for user mode |
| en_sup | input | 1 | Checking enable for supervisor mode |
| call_valid | input | 1 | Call event strobe |
| call_addr | input | 32 | Return address pushed by the call |
| call_page_ok | input | 1 | Push target page carries the shadow attribute |
| ret_valid | input | 1 | Return event strobe |
| ret_addr | input | 32 | Address popped from the data stack |
| ret_page_ok | input | 1 | Pop source page carries the shadow attribute |
| st_valid | input | 1 | Ordinary store strobe |
| st_shadow | input | 1 | Store targets shadow storage |
| fault | output | 1 | Control-protection fault pulse |
| fault_cause | output | 2 | 01 mismatch, 10 page attribute, 11 bound |
| ssp | output | 5 | Shadow pointer; DEPTH means empty |
| st_reject | output | 1 | Ordinary store into shadow storage refused |

## Verification
The bench fills the stack to 16 and pushes once more, then drains it and pops once more. A design with an off-by-one bound would corrupt an entry or read past the end instead of reporting cause 11. It raises page and mismatch faults together to check the priority order, and it sends a call and a return in the same cycle to check the order within a cycle. A design that pushed before popping would compare against the wrong entry. It also faults a return with a call beside it, and a design that kept the call would move the pointer. Shadow stores sit between a push and its pop, so any write that got through shows up as a false mismatch on the later return.

// File: rtl/ssk_pkg.sv
package ssk_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'b00,
    CAUSE_MISMATCH = 2'b01,
    CAUSE_PAGE     = 2'b10,
    CAUSE_BOUND    = 2'b11
  } cause_e;
endpackage

// File: rtl/ssk_mode_gate.sv
module ssk_mode_gate (
  input  logic mode_sup,
  input  logic en_user,
  input  logic en_sup,
  output logic mode_en
);
  always_comb mode_en = mode_sup ? en_sup : en_user;
endmodule

// File: rtl/ssk_store.sv
module ssk_store #(
  parameter int DEPTH = 16,
  parameter int AW    = 32,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [AW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [AW-1:0] rd_data,
  input  logic          st_valid,
  input  logic          st_shadow,
  output logic          st_reject
);
  logic [DEPTH-1:0][AW-1:0] mem;

  // Only the call path reaches the write enable of each entry.
  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n)                               mem[i] <= '0;
      else if (wr_en && (wr_idx == IW'(i)))     mem[i] <= wr_data;
    end
  end

  always_comb rd_data = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) st_reject <= 1'b0;
    else        st_reject <= st_valid & st_shadow;
  end

  p_store_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_shadow && !wr_en) |=> $stable(mem));
  p_store_reject_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_shadow) |=> st_reject);
endmodule

// File: rtl/ssk_engine.sv
module ssk_engine
  import ssk_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 32,
  localparam int IW   = $clog2(DEPTH),
  localparam int PW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_en,
  input  logic          call_valid,
  input  logic [AW-1:0] call_addr,
  input  logic          call_page_ok,
  input  logic          ret_valid,
  input  logic [AW-1:0] ret_addr,
  input  logic          ret_page_ok,
  input  logic [AW-1:0] top_data,
  output logic [IW-1:0] rd_idx,
  output logic          wr_en,
  output logic [IW-1:0] wr_idx,
  output logic [AW-1:0] wr_data,
  output logic [PW-1:0] ssp,
  output logic          fault,
  output logic [1:0]    fault_cause
);
  localparam logic [PW-1:0] EMPTY = PW'(DEPTH);

  cause_e        ret_c, call_c, cyc_c;
  logic [PW-1:0] ssp_mid, ssp_dec, ssp_nxt;
  logic          push_ok;

  always_comb rd_idx = ssp[IW-1:0];

  // Return first: bound, then page, then compare.
  always_comb begin
    ret_c   = CAUSE_NONE;
    ssp_mid = ssp;
    if (mode_en && ret_valid) begin
      if (ssp == EMPTY)              ret_c = CAUSE_BOUND;
      else if (!ret_page_ok)         ret_c = CAUSE_PAGE;
      else if (top_data != ret_addr) ret_c = CAUSE_MISMATCH;
      else                           ssp_mid = ssp + 1'b1;
    end
  end

  // Call second, on the pointer left by the return.
  always_comb begin
    call_c = CAUSE_NONE;
    if (mode_en && call_valid && (ret_c == CAUSE_NONE)) begin
      if (ssp_mid == '0)      call_c = CAUSE_BOUND;
      else if (!call_page_ok) call_c = CAUSE_PAGE;
    end
  end

  always_comb begin
    cyc_c   = (ret_c != CAUSE_NONE) ? ret_c : call_c;
    push_ok = mode_en && call_valid && (cyc_c == CAUSE_NONE);
    ssp_dec = ssp_mid - 1'b1;
    if (cyc_c != CAUSE_NONE) ssp_nxt = ssp;
    else if (push_ok)        ssp_nxt = ssp_dec;
    else                     ssp_nxt = ssp_mid;
    wr_en   = push_ok;
    wr_idx  = ssp_dec[IW-1:0];
    wr_data = call_addr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ssp         <= EMPTY;
      fault       <= 1'b0;
      fault_cause <= CAUSE_NONE;
    end else begin
      ssp         <= ssp_nxt;
      fault       <= (cyc_c != CAUSE_NONE);
      fault_cause <= cyc_c;
    end
  end

  p_ptr_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ssp <= EMPTY);
  p_fault_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (ssp == $past(ssp)));
  p_bound_at_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && fault_cause == CAUSE_BOUND) |-> (ssp == '0 || ssp == EMPTY));
  p_push_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_en && call_valid && !ret_valid) && !fault) |-> (ssp == $past(ssp) - 1'b1));
  p_pop_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_en && ret_valid && !call_valid) && !fault) |-> (ssp == $past(ssp) + 1'b1));
endmodule

// File: rtl/ssk_shadow_stack.sv
module ssk_shadow_stack #(
  parameter int DEPTH = 16,
  parameter int AW    = 32,
  localparam int IW   = $clog2(DEPTH),
  localparam int PW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_sup,
  input  logic          en_user,
  input  logic          en_sup,
  input  logic          call_valid,
  input  logic [AW-1:0] call_addr,
  input  logic          call_page_ok,
  input  logic          ret_valid,
  input  logic [AW-1:0] ret_addr,
  input  logic          ret_page_ok,
  input  logic          st_valid,
  input  logic          st_shadow,
  output logic          fault,
  output logic [1:0]    fault_cause,
  output logic [PW-1:0] ssp,
  output logic          st_reject
);
  logic          mode_en, wr_en;
  logic [IW-1:0] rd_idx, wr_idx;
  logic [AW-1:0] rd_data, wr_data;

  ssk_mode_gate u_gate (
    .mode_sup(mode_sup), .en_user(en_user), .en_sup(en_sup), .mode_en(mode_en)
  );

  ssk_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .st_valid(st_valid), .st_shadow(st_shadow),
    .st_reject(st_reject)
  );

  ssk_engine #(.DEPTH(DEPTH), .AW(AW)) u_engine (
    .clk(clk), .rst_n(rst_n), .mode_en(mode_en),
    .call_valid(call_valid), .call_addr(call_addr), .call_page_ok(call_page_ok),
    .ret_valid(ret_valid), .ret_addr(ret_addr), .ret_page_ok(ret_page_ok),
    .top_data(rd_data), .rd_idx(rd_idx), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .ssp(ssp), .fault(fault), .fault_cause(fault_cause)
  );

  p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_en |=> (!fault && $stable(ssp)));
endmodule

// File: tb/ssk_shadow_stack_test.sv
module ssk_shadow_stack_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        mode_sup, en_user, en_sup;
  logic        call_valid, call_page_ok, ret_valid, ret_page_ok, st_valid, st_shadow;
  logic [31:0] call_addr, ret_addr;
  logic        fault, st_reject;
  logic [1:0]  fault_cause;
  logic [4:0]  ssp;

  int checks = 0, fails = 0;
  logic [31:0] m [16];
  int sp = 16;
  int exp_cause;
  bit exp_rej;
  string tag;

  always #5 clk = ~clk;

  ssk_shadow_stack uut (
    .clk(clk), .rst_n(rst_n), .mode_sup(mode_sup), .en_user(en_user), .en_sup(en_sup),
    .call_valid(call_valid), .call_addr(call_addr), .call_page_ok(call_page_ok),
    .ret_valid(ret_valid), .ret_addr(ret_addr), .ret_page_ok(ret_page_ok),
    .st_valid(st_valid), .st_shadow(st_shadow), .fault(fault),
    .fault_cause(fault_cause), .ssp(ssp), .st_reject(st_reject)
  );

  task automatic chk(string t, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", t, act, exp, $time);
    end
  endtask

  // Expected outcome from the requirements: return first, then call (R10).
  function automatic int predict();
    bit en = mode_sup ? en_sup : en_user;
    int rc = 0, cc = 0, msp = sp, ec;
    if (en && ret_valid) begin
      if (sp == 16)               rc = 3;
      else if (!ret_page_ok)      rc = 2;
      else if (m[sp] != ret_addr) rc = 1;
      else                        msp = sp + 1;
    end
    if (en && call_valid && rc == 0) begin
      if (msp == 0)          cc = 3;
      else if (!call_page_ok) cc = 2;
    end
    ec = (rc != 0) ? rc : cc;
    if (ec == 0) begin
      if (en && call_valid) begin msp--; m[msp] = call_addr; end
      sp = msp;
    end
    if (ec == 1)      tag = "R5";
    else if (ec == 2) tag = "R6";
    else if (ec == 3) tag = "R7";
    else if (!en && (call_valid || ret_valid)) tag = "R2";
    else if (call_valid && ret_valid) tag = "R10";
    else if (call_valid) tag = "R3";
    else tag = "R4";
    return ec;
  endfunction

  task automatic step();
    exp_cause = predict();
    exp_rej   = st_valid && st_shadow;
    @(posedge clk); #1;
    chk({tag, " fault"}, int'(fault), int'(exp_cause != 0));
    if (exp_cause != 0) begin
      chk({tag, " cause"}, int'(fault_cause), exp_cause);
      chk("R8 ptr held", int'(ssp), sp);
    end else chk({tag, " ptr"}, int'(ssp), sp);
    chk("R9 reject", int'(st_reject), int'(exp_rej));
  endtask

  task automatic idle();
    mode_sup = 0; en_user = 1; en_sup = 1;
    call_valid = 0; ret_valid = 0; st_valid = 0; st_shadow = 0;
    call_page_ok = 1; ret_page_ok = 1; call_addr = '0; ret_addr = '0;
  endtask

  task automatic push(logic [31:0] a);
    idle(); call_valid = 1; call_addr = a; step();
  endtask

  task automatic pop(logic [31:0] a);
    idle(); ret_valid = 1; ret_addr = a; step();
  endtask

  initial begin
    #(10 * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    idle();
    repeat (3) @(posedge clk);
    #1;
    chk("R1 ptr", int'(ssp), 16);
    chk("R1 fault", int'(fault), 0);
    chk("R1 reject", int'(st_reject), 0);
    @(negedge clk); rst_n = 1;

    // R11: fill to the top, overflow, drain in LIFO order, underflow.
    for (int i = 0; i < 16; i++) push(32'h1000_0000 + i);
    push(32'hDEAD_0001);                       // R7 overflow
    for (int i = 15; i >= 0; i--) pop(32'h1000_0000 + i);  // R11
    pop(32'h0);                                // R7 underflow

    // R5 mismatch, then the correct return still matches (R8).
    push(32'hCAFE_0000);
    pop(32'hCAFE_0001);
    pop(32'hCAFE_0000);

    // R6 page beats mismatch on a pop; page fault on a push.
    push(32'h2222_0000);
    idle(); ret_valid = 1; ret_addr = 32'h9; ret_page_ok = 0; step();
    idle(); call_valid = 1; call_addr = 32'h5; call_page_ok = 0; step();
    // R7 beats page on an empty pop.
    pop(32'h2222_0000);
    idle(); ret_valid = 1; ret_page_ok = 0; step();

    // R2: supervisor disabled, user enabled, supervisor mode in force.
    idle(); mode_sup = 1; en_sup = 0; call_valid = 1; call_addr = 32'h77; step();
    idle(); mode_sup = 1; en_sup = 0; ret_valid = 1; ret_addr = 32'h1; step();

    // R9: shadow stores between push and pop do not corrupt the entry.
    push(32'h3333_3333);
    idle(); st_valid = 1; st_shadow = 1; step();
    idle(); st_valid = 1; st_shadow = 0; step();
    pop(32'h3333_3333);

    // R10: same-cycle return then call; then a faulting return drops the call.
    push(32'h4444_0000);
    idle(); ret_valid = 1; ret_addr = 32'h4444_0000; call_valid = 1; call_addr = 32'h5555_0000; step();
    idle(); ret_valid = 1; ret_addr = 32'h1; call_valid = 1; call_addr = 32'h6666_0000; step();
    pop(32'h5555_0000);

    // Constrained random traffic.
    for (int n = 0; n < 4000; n++) begin
      idle();
      mode_sup     = 1'($urandom % 2);
      en_user      = ($urandom % 10) != 0;
      en_sup       = ($urandom % 10) != 0;
      call_valid   = ($urandom % 100) < 45;
      ret_valid    = ($urandom % 100) < 40;
      call_page_ok = ($urandom % 100) < 95;
      ret_page_ok  = ($urandom % 100) < 95;
      call_addr    = $urandom;
      ret_addr     = (sp < 16 && ($urandom % 100) < 85) ? m[sp] : $urandom;
      st_valid     = ($urandom % 100) < 20;
      st_shadow    = 1'($urandom % 2);
      step();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule